// File: doc/BRIEF.md
# Regulator Ready Flag Generator

This block produces one active-high "output is good" flag for a multiphase voltage regulator. It combines the enable and supply-health inputs, a one-cycle pulse that marks the end of the soft-start ramp, a digitized sample of the output voltage, the current target voltage code and an overvoltage flag raised by the protection logic.

The flag comes up only after two things have happened in order. First, the block must see a soft-start-done pulse while every qualifying condition is good. Second, a settling window of a parameterized number of clock cycles must then elapse with no fault.

Any disqualifying condition pulls the flag low on the next clock edge. The disqualifying conditions are: either enable low, supply not healthy, the target code equal to the reserved "off" value, an undervoltage, or an overvoltage. Undervoltage means the sample is below the target code shifted right by one bit, which is half the target at the same LSB weight. After any drop, the flag can return only through a fresh soft-start-done pulse followed by the complete settling window.

Top module: `pgood_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `ready` is 0 after that edge, whatever the other inputs are.
- R2: If `ss_done` is 1 at an edge with no disqualifying condition, and no such condition occurs at the following edges, then `ready` becomes 1 exactly `DELAY_CYC` edges after the `ss_done` edge. It is 0 before then.
- R3: Undervoltage is `vsample < (vid_code >> 1)` (unsigned). When it holds at an edge, `ready` is 0 after that edge. A sample exactly equal to the half code is not undervoltage.
- R4: `ov_flag` = 1 at an edge makes `ready` 0 after that edge.
- R5: `en_a` = 0 or `en_b` = 0 at an edge makes `ready` 0 after that edge.
- R6: `supply_ok` = 0 at an edge makes `ready` 0 after that edge.
- R7: `vid_code` equal to `OFF_CODE` (default 8'hFF) at an edge makes `ready` 0 after that edge.
- R8: After `ready` drops, it stays 0 once all conditions are good again, until a new `ss_done` pulse arrives. A `ss_done` pulse seen while a disqualifying condition holds is discarded.
- R9: A disqualifying condition during the settling window discards the elapsed count. The next qualified `ss_done` restarts the full `DELAY_CYC` window.
- R10: An `ss_done` pulse during the settling window does not shift the time at which `ready` rises. An `ss_done` pulse while `ready` is 1 leaves `ready` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_a | input | 1 | First enable; 0 disables |
| en_b | input | 1 | Second enable; 0 disables |
| supply_ok | input | 1 | Power-on reset released; 0 disables |
| ss_done | input | 1 | One-cycle pulse at the end of soft-start |
| vsample | input | W | Digitized output voltage, same LSB weight as `vid_code` |
| vid_code | input | W | Target voltage code |
| ov_flag | input | 1 | Overvoltage detected by protection logic |
| ready | output | 1 | Regulator ready flag, active high |

## Verification
The internal state is a three-way mode plus a settling counter. A wrong mode shows at `ready` on the very next edge: a flag that fails to drop one edge after a fault, or a flag that rises with no fresh soft-start pulse behind it. A counter that does not clear or that misses its terminal count shows as a rise one or more edges early or late. It can also show as a rise that was inherited from a window cut short by a fault. So the checks compare `ready` on every cycle against a predicted sequence, rather than only at the end of a scenario.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

    typedef enum logic [1:0] {
        PG_IDLE   = 2'd0,
        PG_SETTLE = 2'd1,
        PG_READY  = 2'd2
    } pg_state_e;

    typedef struct packed {
        logic disabled;
        logic undervolt;
        logic overvolt;
    } pg_cause_t;

    function automatic logic pg_any(input pg_cause_t c);
        return c.disabled | c.undervolt | c.overvolt;
    endfunction

endpackage

// File: rtl/pgood_qualify.sv
module pgood_qualify
    import pgood_pkg::*;
#(
    parameter int          W        = 8,
    parameter logic [W-1:0] OFF_CODE = '1
) (
    input  logic         en_a,
    input  logic         en_b,
    input  logic         supply_ok,
    input  logic [W-1:0] vsample,
    input  logic [W-1:0] vid_code,
    input  logic         ov_flag,
    output pg_cause_t    cause
);
    logic [W-1:0] half_target;

    always_comb begin
        half_target     = vid_code >> 1;
        cause.disabled  = ~en_a | ~en_b | ~supply_ok | (vid_code == OFF_CODE);
        cause.undervolt = (vsample < half_target);
        cause.overvolt  = ov_flag;
    end
endmodule

// File: rtl/pgood_timer.sv
module pgood_timer #(
    parameter int DELAY_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/pgood_fsm.sv
module pgood_fsm
    import pgood_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pg_cause_t cause,
    input  logic      ss_done,
    input  logic      expired,
    output logic      settling,
    output logic      ready
);
    pg_state_e state;
    logic      drop;

    assign drop = pg_any(cause);

    always_ff @(posedge clk) begin
        if (rst || drop) begin
            state <= PG_IDLE;
        end else begin
            unique case (state)
                PG_IDLE:   if (ss_done) state <= PG_SETTLE;
                PG_SETTLE: if (expired) state <= PG_READY;
                PG_READY:  state <= PG_READY;
                default:   state <= PG_IDLE;
            endcase
        end
    end

    assign settling = (state == PG_SETTLE);
    assign ready    = (state == PG_READY);
endmodule

// File: rtl/pgood_gen.sv
module pgood_gen
    import pgood_pkg::*;
#(
    parameter int          W         = 8,
    parameter logic [W-1:0] OFF_CODE  = '1,
    parameter int          DELAY_CYC = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_a,
    input  logic         en_b,
    input  logic         supply_ok,
    input  logic         ss_done,
    input  logic [W-1:0] vsample,
    input  logic [W-1:0] vid_code,
    input  logic         ov_flag,
    output logic         ready
);
    pg_cause_t cause;
    logic      settling;
    logic      expired;

    pgood_qualify #(.W(W), .OFF_CODE(OFF_CODE)) u_qual (
        .en_a      (en_a),
        .en_b      (en_b),
        .supply_ok (supply_ok),
        .vsample   (vsample),
        .vid_code  (vid_code),
        .ov_flag   (ov_flag),
        .cause     (cause)
    );

    pgood_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (settling),
        .expired (expired)
    );

    pgood_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cause    (cause),
        .ss_done  (ss_done),
        .expired  (expired),
        .settling (settling),
        .ready    (ready)
    );
endmodule

// File: rtl/pgood_chk.sv
module pgood_chk #(
    parameter int          W         = 8,
    parameter logic [W-1:0] OFF_CODE  = '1,
    parameter int          DELAY_CYC = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en_a,
    input logic         en_b,
    input logic         supply_ok,
    input logic         ss_done,
    input logic [W-1:0] vsample,
    input logic [W-1:0] vid_code,
    input logic         ov_flag,
    input logic         ready
);
    logic bad;
    int   clean_run;

    assign bad = !en_a || !en_b || !supply_ok || (vid_code == OFF_CODE)
                 || (vsample < (vid_code >> 1)) || ov_flag;

    always_ff @(posedge clk) begin
        if (rst || bad)
            clean_run <= 0;
        else if (clean_run <= DELAY_CYC)
            clean_run <= clean_run + 1;
    end

    p_reset_low_r1: assert property (@(posedge clk) rst |=> !ready);

    p_full_window_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> clean_run >= DELAY_CYC + 1);

    p_uv_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (vsample < (vid_code >> 1)) |=> !ready);

    p_ov_drop_r4: assert property (@(posedge clk) disable iff (rst)
        ov_flag |=> !ready);

    p_enable_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (!en_a || !en_b) |=> !ready);

    p_supply_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !ready);

    p_offcode_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (vid_code == OFF_CODE) |=> !ready);

    p_stay_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (ready && !bad) |=> ready);
endmodule

bind pgood_gen pgood_chk #(.W(W), .OFF_CODE(OFF_CODE), .DELAY_CYC(DELAY_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_a      (en_a),
    .en_b      (en_b),
    .supply_ok (supply_ok),
    .ss_done   (ss_done),
    .vsample   (vsample),
    .vid_code  (vid_code),
    .ov_flag   (ov_flag),
    .ready     (ready)
);

// File: tb/sim_pgood_gen.sv
`timescale 1ns/1ps
module sim_pgood_gen;
    localparam int W   = 8;
    localparam int DLY = 5;
    localparam logic [W-1:0] OFF = 8'hFF;

    typedef struct {
        bit    exp;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst, en_a, en_b, supply_ok, ss_done, ov_flag, ready;
    logic [W-1:0] vsample, vid_code;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    pgood_gen #(.W(W), .OFF_CODE(OFF), .DELAY_CYC(DLY)) u0 (
        .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b), .supply_ok(supply_ok),
        .ss_done(ss_done), .vsample(vsample), .vid_code(vid_code),
        .ov_flag(ov_flag), .ready(ready)
    );

    // monitor: compares one expected item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (ready !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: ready=%0b expected %0b at %0t", e.req, ready, e.exp, $time);
                end
            end
        end
    end

    // driver: push expectation for the coming edge, then wait past it
    task automatic tick(input bit exp, input string req);
        exp_t e;
        e.exp = exp;
        e.req = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic all_good();
        rst = 0; en_a = 1; en_b = 1; supply_ok = 1; ss_done = 0; ov_flag = 0;
        vid_code = 8'd100; vsample = 8'd100;
    endtask

    task automatic bring_up(input string req);
        ss_done = 1;
        tick(0, req);
        ss_done = 0;
        for (int i = 0; i < DLY - 1; i++) tick(0, req);
        tick(1, req);
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) tick(0, req);
    endtask

    initial begin
        all_good();
        rst = 1;
        ss_done = 1;
        @(negedge clk);
        tick(0, "R1");
        tick(0, "R1");
        rst = 0;
        ss_done = 0;
        quiet(3, "R8");

        // R2 basic bring-up
        bring_up("R2");
        tick(1, "R2");

        // R1: reset while ready
        rst = 1; tick(0, "R1");
        rst = 0; quiet(2, "R8");

        // R3 boundary: sample equal to half code is fine
        bring_up("R3");
        vsample = 8'd50; tick(1, "R3");
        vsample = 8'd49; tick(0, "R3");
        vsample = 8'd100; quiet(DLY + 2, "R8");

        // R4 overvoltage
        bring_up("R2");
        ov_flag = 1; tick(0, "R4");
        ov_flag = 0; quiet(2, "R8");

        // R5 each enable
        bring_up("R2");
        en_a = 0; tick(0, "R5");
        en_a = 1; quiet(1, "R8");
        bring_up("R2");
        en_b = 0; tick(0, "R5");
        en_b = 1; quiet(1, "R8");

        // R6 supply
        bring_up("R2");
        supply_ok = 0; tick(0, "R6");
        supply_ok = 1; quiet(1, "R8");

        // R7 off code; vsample high so no undervoltage involvement
        bring_up("R2");
        vid_code = OFF; vsample = 8'hFF; tick(0, "R7");
        vid_code = 8'd100; vsample = 8'd100; quiet(1, "R8");

        // R8: ss_done during a fault is discarded
        ov_flag = 1; ss_done = 1; tick(0, "R8");
        ov_flag = 0; ss_done = 0; quiet(DLY + 3, "R8");

        // R9: fault mid-window discards the count
        ss_done = 1; tick(0, "R9");
        ss_done = 0; quiet(DLY - 2, "R9");
        vsample = 8'd10; tick(0, "R9");
        vsample = 8'd100; quiet(DLY + 2, "R9");
        bring_up("R9");

        // R10: ss_done while ready has no effect
        ss_done = 1; tick(1, "R10");
        ss_done = 0; tick(1, "R10");

        // R10: ss_done mid-window does not restart the window
        rst = 1; tick(0, "R1");
        rst = 0;
        ss_done = 1; tick(0, "R10");
        ss_done = 0; quiet(1, "R10");
        ss_done = 1; tick(0, "R10");
        ss_done = 0;
        quiet(DLY - 3, "R10");
        tick(1, "R10");

        // different target: half of 200 is 100
        vid_code = 8'd200; vsample = 8'd100; tick(1, "R3");
        vsample = 8'd99; tick(0, "R3");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: ran=1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule